// File: doc/BRIEF.md
# Single-Cell Battery Protection Supervisor

This block is the digital supervisor of a one-cell lithium-ion protector. It receives comparator results that are already digital: the cell voltage against the overcharge, overcharge-release, overdischarge, overdischarge-release and zero-volt levels, and the sense current against the discharge overcurrent, short-circuit, discharge-release, charge overcurrent and charge-release limits. It also receives charger-present and load-present flags. From these it drives the enables of the charge and discharge switches, a pull-down and a pull-up on the current-sense pin, and a shutdown flag for the bias circuits.

Every detect and release condition must stay true for its own delay before the state changes. Each delay is a parameter counted in ticks of a prescaled timebase input. A qualifying counter goes back to zero in the first cycle its condition is false. Leaving a fault needs two things: the level condition held for its release delay, and the charger or load that caused the fault taken away. Some detectors are not looked at in some fault states. The zero-volt flag removes the charge enable in every state.

Top module: `batt_guard_top`

## Requirements
- R1: While `rst` is high, the block goes to the running state in the next clock and clears every delay counter. In the running state `chg_en`=1 and `dis_en`=1 (unless `cell_dead` is high) and `sense_pd`, `sense_pu` and `shutdown` are all 0.
- R2: In the running state, when `cell_hi` has held for OV_DLY ticks, the block enters overcharge on the next clock edge. In overcharge `chg_en`=0, `dis_en`=1, and the sense pull-down, pull-up and shutdown are all 0.
- R3: The block leaves overcharge for the running state only after `cell_hi_clr`=1 and `charger_on`=0 have held together for OVR_DLY ticks. While the charger is present, the block stays in overcharge.
- R4: In overcharge, `dis_oc` is ignored. If `dis_short` holds for SC_DLY ticks, the block enters an overcharge-plus-short state with `chg_en`=0, `dis_en`=0 and `sense_pd`=1. In the first clock where `load_on`=0 and `dis_short`=0, it returns to overcharge.
- R5: In the running state, when `cell_lo` has held for UV_DLY ticks, the block enters overdischarge. Overdischarge gives `chg_en`=1, `dis_en`=0, `sense_pu`=1, `shutdown`=1 and `sense_pd`=0.
- R6: The block leaves overdischarge for the running state only after `charger_on`=1 and `cell_lo_clr`=1 have held together for UVR_DLY ticks. `chg_oc` is ignored during overdischarge.
- R7: In the running state, `dis_oc` held for DOC_DLY ticks, or `dis_short` held for SC_DLY ticks, causes discharge-fault outputs: `chg_en`=1, `dis_en`=0, `sense_pd`=1. The block recovers after `dis_oc_clr`=1 and `load_on`=0 have held together for DOCR_DLY ticks.
- R8: In the running state, when `chg_oc` has held for COC_DLY ticks, the block enters charge overcurrent with `chg_en`=0 and `dis_en`=1. It recovers after `chg_oc_clr`=1 and `charger_on`=0 have held together for COCR_DLY ticks.
- R9: When `cell_dead`=1, `chg_en` is 0 in that same cycle, whatever the state.
- R10: A condition that drops before its delay has expired clears its counter. Two runs of exactly the delay length, separated by a one-cycle gap, do not trip the detector.
- R11: When several detections qualify in the same clock, only one is taken, in this order of precedence: short circuit, discharge overcurrent, overdischarge, charge overcurrent, overcharge.
- R12: Delay counters advance only in cycles where `tick`=1. With `tick` held low, a held condition never trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Prescaled timebase; one cycle high per delay unit |
| cell_hi | input | 1 | Cell at or above the overcharge level |
| cell_hi_clr | input | 1 | Cell below the overcharge release level |
| cell_lo | input | 1 | Cell below the overdischarge level |
| cell_lo_clr | input | 1 | Cell above the overdischarge release level |
| dis_oc | input | 1 | Discharge overcurrent |
| dis_short | input | 1 | Short-circuit current |
| dis_oc_clr | input | 1 | Discharge current back under the release limit |
| chg_oc | input | 1 | Charge overcurrent |
| chg_oc_clr | input | 1 | Charge current back under the release limit |
| charger_on | input | 1 | Charger connected |
| load_on | input | 1 | Load connected |
| cell_dead | input | 1 | Cell below the zero-volt charge inhibit level |
| chg_en | output | 1 | Charge switch enable |
| dis_en | output | 1 | Discharge switch enable |
| sense_pd | output | 1 | Sense-pin pull-down enable |
| sense_pu | output | 1 | Sense-pin pull-up enable |
| shutdown | output | 1 | Bias shutdown request |

## Verification
The bench shortens every delay to a few ticks. Overcharge, overdischarge, discharge overcurrent and charge overcurrent all get the same delay of 5, so two or three of them qualify on the same edge and the precedence order can be seen at the outputs. The short-circuit delay is 1, which puts the shorter short-circuit path and its exit from the overcharge state within a few cycles. The bench also drives the timebase at full rate, at one tick in three, and stopped. This exercises the exact detect and release edges, the clearing of counters on a gap, and the rule that counters advance only on a tick.

// File: rtl/batt_guard_pkg.sv
package batt_guard_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_FULL,
        ST_FULL_SC,
        ST_EMPTY,
        ST_DOC,
        ST_SC,
        ST_COC
    } gstate_e;

    localparam int NQ     = 9;
    localparam int Q_OVD  = 0;
    localparam int Q_OVR  = 1;
    localparam int Q_UVD  = 2;
    localparam int Q_UVR  = 3;
    localparam int Q_DOC  = 4;
    localparam int Q_SC   = 5;
    localparam int Q_DOCR = 6;
    localparam int Q_COC  = 7;
    localparam int Q_COCR = 8;

    typedef struct packed {
        logic cell_hi;
        logic cell_hi_clr;
        logic cell_lo;
        logic cell_lo_clr;
        logic dis_oc;
        logic dis_short;
        logic dis_oc_clr;
        logic chg_oc;
        logic chg_oc_clr;
        logic charger_on;
        logic load_on;
    } sense_t;

    typedef struct packed {
        logic chg_en;
        logic dis_en;
        logic sense_pd;
        logic sense_pu;
        logic shutdown;
    } drive_t;

    function automatic int cnt_width(int lim);
        return (lim < 1) ? 1 : $clog2(lim + 1);
    endfunction

    function automatic drive_t drive_of(gstate_e s);
        drive_t d;
        d = '{chg_en: 1'b1, dis_en: 1'b1, sense_pd: 1'b0, sense_pu: 1'b0, shutdown: 1'b0};
        case (s)
            ST_FULL:    d.chg_en = 1'b0;
            ST_FULL_SC: begin d.chg_en = 1'b0; d.dis_en = 1'b0; d.sense_pd = 1'b1; end
            ST_EMPTY:   begin d.dis_en = 1'b0; d.sense_pu = 1'b1; d.shutdown = 1'b1; end
            ST_DOC,
            ST_SC:      begin d.dis_en = 1'b0; d.sense_pd = 1'b1; end
            ST_COC:     d.chg_en = 1'b0;
            default:    ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bg_qualifier.sv
module bg_qualifier #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cond,
    output logic hit
);
    localparam int CW = batt_guard_pkg::cnt_width(LIMIT);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !cond)
            cnt <= '0;
        else if (tick && (cnt < LIM_V))
            cnt <= cnt + 1'b1;
    end

    assign hit = cond && (cnt >= LIM_V);
endmodule

// File: rtl/bg_fsm.sv
module bg_fsm
    import batt_guard_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  sense_t          sense,
    input  logic [NQ-1:0]   hit,
    output logic [NQ-1:0]   cond,
    output gstate_e         state
);
    gstate_e state_nxt;

    always_comb begin
        cond         = '0;
        cond[Q_OVD]  = (state == ST_RUN) && sense.cell_hi;
        cond[Q_OVR]  = (state == ST_FULL) && sense.cell_hi_clr && !sense.charger_on;
        cond[Q_UVD]  = (state == ST_RUN) && sense.cell_lo;
        cond[Q_UVR]  = (state == ST_EMPTY) && sense.charger_on && sense.cell_lo_clr;
        cond[Q_DOC]  = (state == ST_RUN) && sense.dis_oc;
        cond[Q_SC]   = ((state == ST_RUN) || (state == ST_FULL)) && sense.dis_short;
        cond[Q_DOCR] = ((state == ST_DOC) || (state == ST_SC)) && sense.dis_oc_clr && !sense.load_on;
        cond[Q_COC]  = (state == ST_RUN) && sense.chg_oc;
        cond[Q_COCR] = (state == ST_COC) && sense.chg_oc_clr && !sense.charger_on;
    end

    always_comb begin
        state_nxt = state;
        case (state)
            ST_RUN: begin
                if (hit[Q_SC])        state_nxt = ST_SC;
                else if (hit[Q_DOC])  state_nxt = ST_DOC;
                else if (hit[Q_UVD])  state_nxt = ST_EMPTY;
                else if (hit[Q_COC])  state_nxt = ST_COC;
                else if (hit[Q_OVD])  state_nxt = ST_FULL;
            end
            ST_FULL: begin
                if (hit[Q_SC])        state_nxt = ST_FULL_SC;
                else if (hit[Q_OVR])  state_nxt = ST_RUN;
            end
            ST_FULL_SC: begin
                if (!sense.load_on && !sense.dis_short) state_nxt = ST_FULL;
            end
            ST_EMPTY: begin
                if (hit[Q_UVR])       state_nxt = ST_RUN;
            end
            ST_DOC, ST_SC: begin
                if (hit[Q_DOCR])      state_nxt = ST_RUN;
            end
            ST_COC: begin
                if (hit[Q_COCR])      state_nxt = ST_RUN;
            end
            default:                  state_nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nxt;
    end
endmodule

// File: rtl/bg_outdec.sv
module bg_outdec
    import batt_guard_pkg::*;
(
    input  gstate_e state,
    input  logic    cell_dead,
    output drive_t  drv
);
    drive_t base;

    always_comb begin
        base       = drive_of(state);
        drv        = base;
        drv.chg_en = base.chg_en && !cell_dead;
    end
endmodule

// File: rtl/batt_guard_top.sv
module batt_guard_top
    import batt_guard_pkg::*;
#(
    parameter int OV_DLY   = 1000,
    parameter int OVR_DLY  = 16,
    parameter int UV_DLY   = 20,
    parameter int UVR_DLY  = 1,
    parameter int DOC_DLY  = 12,
    parameter int SC_DLY   = 1,
    parameter int DOCR_DLY = 4,
    parameter int COC_DLY  = 16,
    parameter int COCR_DLY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cell_hi,
    input  logic cell_hi_clr,
    input  logic cell_lo,
    input  logic cell_lo_clr,
    input  logic dis_oc,
    input  logic dis_short,
    input  logic dis_oc_clr,
    input  logic chg_oc,
    input  logic chg_oc_clr,
    input  logic charger_on,
    input  logic load_on,
    input  logic cell_dead,
    output logic chg_en,
    output logic dis_en,
    output logic sense_pd,
    output logic sense_pu,
    output logic shutdown
);
    localparam int LIMS [NQ] = '{OV_DLY, OVR_DLY, UV_DLY, UVR_DLY, DOC_DLY,
                                 SC_DLY, DOCR_DLY, COC_DLY, COCR_DLY};

    sense_t        sense;
    logic [NQ-1:0] cond;
    logic [NQ-1:0] hit;
    gstate_e       state;
    drive_t        drv;

    assign sense = '{cell_hi: cell_hi, cell_hi_clr: cell_hi_clr, cell_lo: cell_lo,
                     cell_lo_clr: cell_lo_clr, dis_oc: dis_oc, dis_short: dis_short,
                     dis_oc_clr: dis_oc_clr, chg_oc: chg_oc, chg_oc_clr: chg_oc_clr,
                     charger_on: charger_on, load_on: load_on};

    for (genvar g = 0; g < NQ; g++) begin : g_qual
        bg_qualifier #(.LIMIT(LIMS[g])) u_q (
            .clk  (clk),
            .rst  (rst),
            .tick (tick),
            .cond (cond[g]),
            .hit  (hit[g])
        );
    end

    bg_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .sense (sense),
        .hit   (hit),
        .cond  (cond),
        .state (state)
    );

    bg_outdec u_out (
        .state     (state),
        .cell_dead (cell_dead),
        .drv       (drv)
    );

    assign chg_en   = drv.chg_en;
    assign dis_en   = drv.dis_en;
    assign sense_pd = drv.sense_pd;
    assign sense_pu = drv.sense_pu;
    assign shutdown = drv.shutdown;
endmodule

// File: rtl/batt_guard_checker.sv
module batt_guard_checker (
    input logic clk,
    input logic rst,
    input logic cell_dead,
    input logic chg_en,
    input logic dis_en,
    input logic sense_pd,
    input logic sense_pu,
    input logic shutdown
);
    // R9: a dead cell never sees the charge switch on
    a_r9_dead_blocks_charge: assert property (@(posedge clk) disable iff (rst)
        cell_dead |-> !chg_en);

    // R5: shutdown only together with the overdischarge pattern
    a_r5_shutdown_pattern: assert property (@(posedge clk) disable iff (rst)
        shutdown |-> (sense_pu && !dis_en && !sense_pd));

    // R7: pull-down only while discharge is blocked
    a_r7_pulldown_blocks_discharge: assert property (@(posedge clk) disable iff (rst)
        sense_pd |-> !dis_en);

    // R4: both switches off only in the short state or with a dead cell
    a_r4_both_off_needs_pd: assert property (@(posedge clk) disable iff (rst)
        (!chg_en && !dis_en) |-> (sense_pd || cell_dead));

    // R1: first cycle after reset shows the running pattern
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dis_en && !sense_pd && !sense_pu && !shutdown && (chg_en || cell_dead)));
endmodule

bind batt_guard_top batt_guard_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cell_dead (cell_dead),
    .chg_en    (chg_en),
    .dis_en    (dis_en),
    .sense_pd  (sense_pd),
    .sense_pu  (sense_pu),
    .shutdown  (shutdown)
);

// File: tb/tb_batt_guard_top.sv
`timescale 1ns/1ps
module tb_batt_guard_top;
    localparam int P_OV = 5, P_OVR = 3, P_UV = 5, P_UVR = 2, P_DOC = 5;
    localparam int P_SC = 1, P_DOCR = 3, P_COC = 5, P_COCR = 3;

    logic clk = 0, rst = 1, tick = 0;
    logic cell_hi = 0, cell_hi_clr = 0, cell_lo = 0, cell_lo_clr = 0;
    logic dis_oc = 0, dis_short = 0, dis_oc_clr = 0, chg_oc = 0, chg_oc_clr = 0;
    logic charger_on = 0, load_on = 0, cell_dead = 0;
    logic chg_en, dis_en, sense_pd, sense_pu, shutdown;

    batt_guard_top #(.OV_DLY(P_OV), .OVR_DLY(P_OVR), .UV_DLY(P_UV), .UVR_DLY(P_UVR),
                     .DOC_DLY(P_DOC), .SC_DLY(P_SC), .DOCR_DLY(P_DOCR),
                     .COC_DLY(P_COC), .COCR_DLY(P_COCR)) dut (
        .clk(clk), .rst(rst), .tick(tick), .cell_hi(cell_hi), .cell_hi_clr(cell_hi_clr),
        .cell_lo(cell_lo), .cell_lo_clr(cell_lo_clr), .dis_oc(dis_oc), .dis_short(dis_short),
        .dis_oc_clr(dis_oc_clr), .chg_oc(chg_oc), .chg_oc_clr(chg_oc_clr),
        .charger_on(charger_on), .load_on(load_on), .cell_dead(cell_dead),
        .chg_en(chg_en), .dis_en(dis_en), .sense_pd(sense_pd), .sense_pu(sense_pu),
        .shutdown(shutdown));

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit done = 0;

    // timebase: 0 = stopped, n = one tick every n cycles
    int tick_div = 1, tick_cnt = 0;
    always @(negedge clk) begin
        if (tick_div == 0) begin
            tick = 0; tick_cnt = 0;
        end else begin
            tick = (tick_cnt == 0);
            tick_cnt = (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
        end
    end

    // behavioural reference: mode codes 0 run,1 full,2 full+short,3 empty,4 doc,5 short,6 coc
    int ms = 0;
    int mc [9];
    int lim [9] = '{P_OV, P_OVR, P_UV, P_UVR, P_DOC, P_SC, P_DOCR, P_COC, P_COCR};

    always @(posedge clk) begin
        bit c [9];
        bit q [9];
        int nx;
        if (rst) begin
            ms = 0;
            foreach (mc[i]) mc[i] = 0;
        end else begin
            c[0] = (ms == 0) && cell_hi;
            c[1] = (ms == 1) && cell_hi_clr && !charger_on;
            c[2] = (ms == 0) && cell_lo;
            c[3] = (ms == 3) && charger_on && cell_lo_clr;
            c[4] = (ms == 0) && dis_oc;
            c[5] = (ms == 0 || ms == 1) && dis_short;
            c[6] = (ms == 4 || ms == 5) && dis_oc_clr && !load_on;
            c[7] = (ms == 0) && chg_oc;
            c[8] = (ms == 6) && chg_oc_clr && !charger_on;
            foreach (q[i]) q[i] = c[i] && (mc[i] >= lim[i]);
            nx = ms;
            if (ms == 0) begin
                if (q[5]) nx = 5; else if (q[4]) nx = 4; else if (q[2]) nx = 3;
                else if (q[7]) nx = 6; else if (q[0]) nx = 1;
            end else if (ms == 1) begin
                if (q[5]) nx = 2; else if (q[1]) nx = 0;
            end else if (ms == 2) begin
                if (!load_on && !dis_short) nx = 1;
            end else if (ms == 3) begin
                if (q[3]) nx = 0;
            end else if (ms == 4 || ms == 5) begin
                if (q[6]) nx = 0;
            end else begin
                if (q[8]) nx = 0;
            end
            foreach (mc[i]) begin
                if (!c[i]) mc[i] = 0;
                else if (tick && mc[i] < lim[i]) mc[i] = mc[i] + 1;
            end
            ms = nx;
        end
    end

    function automatic logic [4:0] model_out(int m, logic dead);
        logic [4:0] o;
        case (m)
            1: o = 5'b01000;
            2: o = 5'b00100;
            3: o = 5'b10011;
            4, 5: o = 5'b10100;
            6: o = 5'b01000;
            default: o = 5'b11000;
        endcase
        if (dead) o[4] = 1'b0;
        return o;
    endfunction

    // compare with the reference every clock, away from the edge
    always @(posedge clk) begin
        logic [4:0] act, exp;
        #1;
        if (!rst && !done) begin
            act = {chg_en, dis_en, sense_pd, sense_pu, shutdown};
            exp = model_out(ms, cell_dead);
            checks++;
            if (act !== exp) begin
                errors++;
                $display("FAIL %s model compare at %0t: actual %b expected %b", cur_req, $time, act, exp);
            end
        end
    end

    localparam logic [4:0] O_RUN = 5'b11000, O_FULL = 5'b01000, O_FSC = 5'b00100;
    localparam logic [4:0] O_EMPTY = 5'b10011, O_DOC = 5'b10100, O_COC = 5'b01000;

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(logic [4:0] exp, string req);
        logic [4:0] act;
        act = {chg_en, dis_en, sense_pd, sense_pu, shutdown};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s directed at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired: actual hung expected finish");
        done = 1;
        summary();
        $finish;
    end

    initial begin
        cyc(3);
        rst = 0;
        cur_req = "R1"; expect_out(O_RUN, "R1");

        cur_req = "R2"; cell_hi = 1;
        cyc(P_OV); expect_out(O_RUN, "R2");
        cyc(1);    expect_out(O_FULL, "R2");
        cell_hi = 0;

        cur_req = "R3"; charger_on = 1; cell_hi_clr = 1;
        cyc(8); expect_out(O_FULL, "R3");
        charger_on = 0;
        cyc(P_OVR); expect_out(O_FULL, "R3");
        cyc(1);     expect_out(O_RUN, "R3");
        cell_hi_clr = 0;

        cur_req = "R4"; charger_on = 1; cell_hi = 1;
        cyc(P_OV + 1); expect_out(O_FULL, "R4");
        cell_hi = 0; dis_oc = 1; load_on = 1;
        cyc(P_DOC + 4); expect_out(O_FULL, "R4");
        dis_oc = 0; dis_short = 1;
        cyc(P_SC); expect_out(O_FULL, "R4");
        cyc(1);    expect_out(O_FSC, "R4");
        dis_short = 0;
        cyc(4); expect_out(O_FSC, "R4");
        load_on = 0;
        cyc(1); expect_out(O_FULL, "R4");
        charger_on = 0; cell_hi_clr = 1;
        cyc(P_OVR + 1); expect_out(O_RUN, "R4");
        cell_hi_clr = 0;

        cur_req = "R5"; cell_lo = 1;
        cyc(P_UV); expect_out(O_RUN, "R5");
        cyc(1);    expect_out(O_EMPTY, "R5");
        cell_lo = 0;

        cur_req = "R6"; chg_oc = 1;
        cyc(P_COC + 3); expect_out(O_EMPTY, "R6");
        chg_oc = 0; cell_lo_clr = 1;
        cyc(6); expect_out(O_EMPTY, "R6");
        charger_on = 1;
        cyc(P_UVR); expect_out(O_EMPTY, "R6");
        cyc(1);     expect_out(O_RUN, "R6");
        charger_on = 0; cell_lo_clr = 0;

        cur_req = "R7"; load_on = 1; dis_oc = 1;
        cyc(P_DOC); expect_out(O_RUN, "R7");
        cyc(1);     expect_out(O_DOC, "R7");
        dis_oc = 0; dis_oc_clr = 1;
        cyc(6); expect_out(O_DOC, "R7");
        load_on = 0;
        cyc(P_DOCR); expect_out(O_DOC, "R7");
        cyc(1);      expect_out(O_RUN, "R7");
        load_on = 1; dis_short = 1;
        cyc(P_SC); expect_out(O_RUN, "R7");
        cyc(1);    expect_out(O_DOC, "R7");
        dis_short = 0; load_on = 0;
        cyc(P_DOCR); expect_out(O_DOC, "R7");
        cyc(1);      expect_out(O_RUN, "R7");
        dis_oc_clr = 0;

        cur_req = "R8"; chg_oc = 1;
        cyc(P_COC); expect_out(O_RUN, "R8");
        cyc(1);     expect_out(O_COC, "R8");
        chg_oc = 0; chg_oc_clr = 1; charger_on = 1;
        cyc(6); expect_out(O_COC, "R8");
        charger_on = 0;
        cyc(P_COCR); expect_out(O_COC, "R8");
        cyc(1);      expect_out(O_RUN, "R8");
        chg_oc_clr = 0;

        cur_req = "R9"; cell_dead = 1;
        #1 expect_out(5'b01000, "R9");
        cell_lo = 1;
        cyc(P_UV + 1); expect_out(5'b00011, "R9");
        cell_dead = 0;
        #1 expect_out(O_EMPTY, "R9");
        cell_lo = 0; charger_on = 1; cell_lo_clr = 1;
        cyc(P_UVR + 1); expect_out(O_RUN, "R9");
        charger_on = 0; cell_lo_clr = 0;

        cur_req = "R10"; cell_hi = 1;
        cyc(P_OV); cell_hi = 0;
        cyc(1);    cell_hi = 1;
        cyc(P_OV); expect_out(O_RUN, "R10");
        cell_hi = 0;
        cyc(2); expect_out(O_RUN, "R10");

        cur_req = "R11"; dis_oc = 1; cell_lo = 1; chg_oc = 1; load_on = 1;
        cyc(P_DOC + 1); expect_out(O_DOC, "R11");
        dis_oc = 0; cell_lo = 0; chg_oc = 0; load_on = 0; dis_oc_clr = 1;
        cyc(P_DOCR + 1); expect_out(O_RUN, "R11");
        dis_oc_clr = 0; cell_lo = 1; chg_oc = 1;
        cyc(P_UV + 1); expect_out(O_EMPTY, "R11");
        cell_lo = 0; chg_oc = 0; charger_on = 1; cell_lo_clr = 1;
        cyc(P_UVR + 1); expect_out(O_RUN, "R11");
        charger_on = 0; cell_lo_clr = 0; chg_oc = 1; cell_hi = 1;
        cyc(P_COC + 1); expect_out(O_COC, "R11");
        chg_oc = 0; cell_hi = 0; chg_oc_clr = 1;
        cyc(P_COCR + 1); expect_out(O_RUN, "R11");
        chg_oc_clr = 0;

        cur_req = "R12"; tick_div = 0;
        cyc(1); cell_hi = 1;
        cyc(20); expect_out(O_RUN, "R12");
        tick_div = 3;
        cyc(3 * (P_OV + 1) + 3); expect_out(O_FULL, "R12");
        cell_hi = 0; tick_div = 1; cell_hi_clr = 1;
        cyc(10); expect_out(O_RUN, "R12");
        cell_hi_clr = 0;

        cyc(2);
        done = 1;
        summary();
        $finish;
    end
endmodule